// File: doc/BRIEF.md
# Digital Correlated Double Sampler

This block turns a stream of unsigned ADC codes taken from a CCD video waveform into one signed charge amplitude per pixel. A pixel-start strobe marks the beginning of each pixel period. After the strobe, every accepted sample gets an index. Three windows are compared against that index: a baseline window placed after the reset settles, a signal window placed after the charge transfer, and an optional second baseline window placed after the signal. Samples outside these windows are ignored. This covers the reset pulse and its feed-through, the settling transients and the transfer disturbance. An electron packet pulls the video level down, so the amplitude is the baseline level minus the signal level.

Window positions and a common window length come from static configuration inputs, so the integration length can shrink as the pixel rate rises. Every result is scaled to two times the per-sample sum. Single-baseline mode doubles its one baseline sum. Dual-baseline mode adds the two baseline sums. The two modes therefore share one scale, and no divider is needed. For devices that can be read without destroying the charge, a repeat count makes the block add the results of several consecutive reads of the same packet and emit one total. The caller divides that total by the read count to get the mean. If a new strobe arrives while a read is still open, the pixel is discarded and a sticky error flag is set.

Top module: `dcds_engine`

## Requirements
- R1: After reset, amp_valid and err_flag are 0 and amp_out is 0.
- R2: A cycle with pix_start high restarts the sample index. The first sample accepted in a later cycle (smp_valid high) gets index 0, and each further accepted sample adds one. Samples in the strobe cycle, cycles with smp_valid low, and samples after the last window has closed are not counted.
- R3: A sample with index i belongs to a window with start offset F when F <= i < F + cfg_win_len. Samples outside every window have no effect on the result.
- R4: With cfg_dual = 0, the result is 2*(baseline sum - signal sum) in two's complement. The result is negative when the signal level is above the baseline.
- R5: With cfg_dual = 1, the result is baseline sum + second-baseline sum - 2*signal sum. The second baseline window uses cfg_base2_first and the same length as the other windows.
- R6: A read closes on the accepted sample whose index is the last index of the final window. That window is the second baseline window in dual mode and the signal window otherwise. amp_valid is high for exactly one cycle, in the cycle after that sample's clock edge, with amp_out holding the result.
- R7: With cfg_reads = N >= 2, the results of N consecutive closed reads are added together. A single amp_valid pulse follows the N-th read. Values 0 and 1 both mean one read per output.
- R8: A pix_start while a read is open discards that read and any partial repeat total, and produces no output. It also sets err_flag, which stays set until reset. The strobe still starts a fresh read.
- R9: At full-scale code 4095, the maximum window length of 63 and the maximum read count of 15, the output is exact in both signs (±7739550).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_start | input | 1 | Pixel-period start strobe |
| smp_valid | input | 1 | ADC sample present on smp_data |
| smp_data | input | DATA_W | Unsigned ADC code |
| cfg_base_first | input | IDX_W | Start index of the baseline window |
| cfg_sig_first | input | IDX_W | Start index of the signal window |
| cfg_base2_first | input | IDX_W | Start index of the second baseline window |
| cfg_win_len | input | LEN_W | Samples per window, 1 or more |
| cfg_dual | input | 1 | Use the second baseline window |
| cfg_reads | input | REP_W | Reads combined per output |
| amp_valid | output | 1 | One-cycle result strobe |
| amp_out | output | OUT_W | Signed amplitude, twice the per-sample sum |
| err_flag | output | 1 | Sticky early-strobe error |

## Verification
The bench surrounds every window with junk codes and strobe-cycle samples. A design that let a reset or transfer sample leak into a sum would report a wrong amplitude. It inserts gaps in smp_valid, which a design counting cycles instead of samples would misplace. It checks the exact cycle of each result, which catches an extra or missing pipeline stage. Repeat totals are checked only after the final read, so an early pulse shows up. An abort in the middle of a repeat sequence must not leave a partial total behind. Full-scale reads at maximum length and maximum count expose any accumulator that is too narrow.

// File: rtl/dcds_pkg.sv
package dcds_pkg;

    localparam int unsigned NUM_WIN   = 3;
    localparam int unsigned WIN_BASE  = 0;
    localparam int unsigned WIN_SIG   = 1;
    localparam int unsigned WIN_BASE2 = 2;

    // true when idx falls inside [first, first+len)
    function automatic logic idx_in_window(input int unsigned idx,
                                           input int unsigned first,
                                           input int unsigned len);
        return (idx >= first) && (idx < first + len);
    endfunction

endpackage

// File: rtl/dcds_win_acc.sv
module dcds_win_acc #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned SUM_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] smp,
    output logic [SUM_W-1:0]  sum_nxt
);

    logic [SUM_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add) begin
            sum_d = sum_q + SUM_W'(smp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum_nxt = sum_d;

endmodule

// File: rtl/dcds_rep_acc.sv
module dcds_rep_acc #(
    parameter int unsigned CDS_W = 20,
    parameter int unsigned REP_W = 4,
    parameter int unsigned OUT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    abort,
    input  logic                    read_done,
    input  logic signed [CDS_W-1:0] cds,
    input  logic [REP_W-1:0]        cfg_reads,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_amp
);

    typedef struct packed {
        logic [REP_W-1:0]        cnt;
        logic signed [OUT_W-1:0] acc;
        logic                    vld;
        logic signed [OUT_W-1:0] amp;
    } rep_t;

    rep_t rep_d, rep_q;
    logic signed [OUT_W-1:0] total;
    logic                    last_read;

    always_comb begin
        rep_d     = rep_q;
        rep_d.vld = 1'b0;
        total     = rep_q.acc + {{(OUT_W-CDS_W){cds[CDS_W-1]}}, cds};
        last_read = ({1'b0, rep_q.cnt} + 1'b1) >= {1'b0, cfg_reads};
        if (abort) begin
            rep_d.cnt = '0;
            rep_d.acc = '0;
        end else if (read_done) begin
            if (last_read) begin
                rep_d.vld = 1'b1;
                rep_d.amp = total;
                rep_d.cnt = '0;
                rep_d.acc = '0;
            end else begin
                rep_d.acc = total;
                rep_d.cnt = rep_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign out_valid = rep_q.vld;
    assign out_amp   = rep_q.amp;

endmodule

// File: rtl/dcds_engine.sv
module dcds_engine
    import dcds_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned LEN_W  = 6,
    parameter int unsigned REP_W  = 4,
    localparam int unsigned SUM_W = DATA_W + LEN_W,
    localparam int unsigned CDS_W = SUM_W + 2,
    localparam int unsigned OUT_W = CDS_W + REP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_start,
    input  logic                    smp_valid,
    input  logic [DATA_W-1:0]       smp_data,
    input  logic [IDX_W-1:0]        cfg_base_first,
    input  logic [IDX_W-1:0]        cfg_sig_first,
    input  logic [IDX_W-1:0]        cfg_base2_first,
    input  logic [LEN_W-1:0]        cfg_win_len,
    input  logic                    cfg_dual,
    input  logic [REP_W-1:0]        cfg_reads,
    output logic                    amp_valid,
    output logic signed [OUT_W-1:0] amp_out,
    output logic                    err_flag
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]   win_first [NUM_WIN];
    logic [NUM_WIN-1:0] win_add;
    logic [SUM_W-1:0]   win_sum [NUM_WIN];
    logic               clr_all, abort, read_done;
    int                 last_idx;
    logic               busy_mon;

    assign win_first[WIN_BASE]  = cfg_base_first;
    assign win_first[WIN_SIG]   = cfg_sig_first;
    assign win_first[WIN_BASE2] = cfg_base2_first;

    // sequencing of one read: strobe, index count, window hits, close
    always_comb begin
        ctl_d     = ctl_q;
        clr_all   = 1'b0;
        abort     = 1'b0;
        read_done = 1'b0;
        win_add   = '0;
        last_idx  = int'(cfg_dual ? cfg_base2_first : cfg_sig_first)
                  + int'(cfg_win_len) - 1;
        if (pix_start) begin
            clr_all = 1'b1;
            if (ctl_q.busy) begin
                abort     = 1'b1;
                ctl_d.err = 1'b1;
            end
            ctl_d.busy = 1'b1;
            ctl_d.idx  = '0;
        end else if (smp_valid && ctl_q.busy) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                win_add[w] = idx_in_window(int'(ctl_q.idx), int'(win_first[w]),
                                           int'(cfg_win_len));
            end
            win_add[WIN_BASE2] = win_add[WIN_BASE2] & cfg_dual;
            if (int'(ctl_q.idx) == last_idx) begin
                read_done  = 1'b1;
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dcds_win_acc #(
            .DATA_W(DATA_W),
            .SUM_W (SUM_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_all),
            .add    (win_add[g]),
            .smp    (smp_data),
            .sum_nxt(win_sum[g])
        );
    end

    // both modes land on twice the per-sample scale
    logic [SUM_W:0]          base_tot, sig_dbl;
    logic signed [CDS_W-1:0] cds;

    always_comb begin
        base_tot = cfg_dual ? ({1'b0, win_sum[WIN_BASE]} + {1'b0, win_sum[WIN_BASE2]})
                            : {win_sum[WIN_BASE], 1'b0};
        sig_dbl  = {win_sum[WIN_SIG], 1'b0};
        cds      = $signed({1'b0, base_tot}) - $signed({1'b0, sig_dbl});
    end

    dcds_rep_acc #(
        .CDS_W(CDS_W),
        .REP_W(REP_W),
        .OUT_W(OUT_W)
    ) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .read_done(read_done),
        .cds      (cds),
        .cfg_reads(cfg_reads),
        .out_valid(amp_valid),
        .out_amp  (amp_out)
    );

    assign err_flag = ctl_q.err;
    assign busy_mon = ctl_q.busy;

endmodule

// File: rtl/dcds_engine_chk.sv
module dcds_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic pix_start,
    input logic busy,
    input logic amp_valid,
    input logic err_flag
);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid |=> !amp_valid);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid |-> !busy);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R8
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_start && busy) |=> err_flag);

    // R2
    strobe_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_start |=> !amp_valid);

endmodule

bind dcds_engine dcds_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_start(pix_start),
    .busy     (busy_mon),
    .amp_valid(amp_valid),
    .err_flag (err_flag)
);

// File: tb/dcds_engine_tb.sv
module dcds_engine_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_start = 1'b0;
    logic              smp_valid = 1'b0;
    logic [11:0]       smp_data = '0;
    logic [7:0]        cfg_base_first = '0;
    logic [7:0]        cfg_sig_first = '0;
    logic [7:0]        cfg_base2_first = '0;
    logic [5:0]        cfg_win_len = 6'd1;
    logic              cfg_dual = 1'b0;
    logic [3:0]        cfg_reads = '0;
    logic              amp_valid;
    logic signed [23:0] amp_out;
    logic              err_flag;

    int     total = 0;
    int     bad = 0;
    int     cyc = 0;
    int     vcount = 0;
    int     vcyc = 0;
    int     drive_cyc = 0;
    longint last_amp = 0;
    bit     finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (amp_valid) begin
            vcount++;
            vcyc = cyc;
            last_amp = longint'(amp_out);
        end
    end

    dcds_engine dut_i (
        .clk(clk), .rst_n(rst_n), .pix_start(pix_start),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_base_first(cfg_base_first), .cfg_sig_first(cfg_sig_first),
        .cfg_base2_first(cfg_base2_first), .cfg_win_len(cfg_win_len),
        .cfg_dual(cfg_dual), .cfg_reads(cfg_reads),
        .amp_valid(amp_valid), .amp_out(amp_out), .err_flag(err_flag)
    );

    task automatic check(input string req, input longint got, input longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int smp_val(int i, int b, int s, int b2);
        int ln = int'(cfg_win_len);
        if (cfg_dual && i >= int'(cfg_base2_first) && i < int'(cfg_base2_first) + ln) return b2;
        if (i >= int'(cfg_sig_first) && i < int'(cfg_sig_first) + ln) return s;
        if (i >= int'(cfg_base_first) && i < int'(cfg_base_first) + ln) return b;
        return (i * 37 + 2900) % 4096;
    endfunction

    function automatic longint exp_read(int b, int s, int b2);
        longint ln = longint'(cfg_win_len);
        if (cfg_dual) return ln * b + ln * b2 - 2 * ln * s;
        return 2 * ln * (b - s);
    endfunction

    task automatic strobe();
        @(negedge clk);
        pix_start = 1'b1;
        smp_valid = 1'b1;
        smp_data  = 12'hFFF;
        @(negedge clk);
        pix_start = 1'b0;
        smp_valid = 1'b0;
    endtask

    task automatic do_read(input int b, input int s, input int b2,
                           input bit gaps, input int extra);
        int last = int'(cfg_dual ? cfg_base2_first : cfg_sig_first) + int'(cfg_win_len) - 1;
        strobe();
        for (int i = 0; i <= last + extra; i++) begin
            if (gaps && (i % 3 == 1)) begin
                smp_valid = 1'b0;
                smp_data  = 12'hABC;
                @(negedge clk);
            end
            smp_valid = 1'b1;
            smp_data  = 12'(smp_val(i, b, s, b2));
            if (i == last) drive_cyc = cyc;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic partial_read(input int n);
        strobe();
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_data  = 12'd100;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic set_cfg(input int bf, input int sf, input int b2f, input int ln,
                           input bit dual, input int reads);
        cfg_base_first  = 8'(bf);
        cfg_sig_first   = 8'(sf);
        cfg_base2_first = 8'(b2f);
        cfg_win_len     = 6'(ln);
        cfg_dual        = dual;
        cfg_reads       = 4'(reads);
    endtask

    task automatic t_reset();
        check("R1 valid", longint'(amp_valid), 0);
        check("R1 err", longint'(err_flag), 0);
        check("R1 amp", longint'(amp_out), 0);
    endtask

    task automatic t_single();
        int base;
        set_cfg(2, 9, 0, 4, 0, 1);
        base = vcount;
        do_read(1000, 700, 0, 0, 0);
        check("R6 count", vcount - base, 1);
        check("R6 timing", vcyc, drive_cyc + 1);
        check("R4 amp", last_amp, exp_read(1000, 700, 0));
    endtask

    task automatic t_negative_gaps();
        int base;
        set_cfg(1, 12, 0, 7, 0, 0);
        base = vcount;
        do_read(500, 900, 0, 1, 0);
        check("R2 gaps count", vcount - base, 1);
        check("R6 timing gaps", vcyc, drive_cyc + 1);
        check("R4 negative", last_amp, exp_read(500, 900, 0));
    endtask

    task automatic t_long_extra();
        int base;
        set_cfg(3, 25, 0, 18, 0, 1);
        base = vcount;
        do_read(2222, 2000, 0, 0, 6);
        check("R2 late samples ignored", vcount - base, 1);
        check("R3 window sum", last_amp, exp_read(2222, 2000, 0));
    endtask

    task automatic t_dual();
        int base;
        set_cfg(1, 8, 15, 5, 1, 1);
        base = vcount;
        do_read(1000, 600, 1010, 0, 0);
        check("R5 dual", last_amp, exp_read(1000, 600, 1010));
        check("R6 dual timing", vcyc, drive_cyc + 1);
        do_read(800, 900, 850, 1, 2);
        check("R5 dual gaps", last_amp, exp_read(800, 900, 850));
        check("R5 count", vcount - base, 2);
    endtask

    task automatic t_repeat();
        int base;
        longint acc;
        set_cfg(2, 9, 0, 4, 0, 3);
        base = vcount;
        do_read(1000, 700, 0, 0, 0);
        do_read(1000, 650, 0, 0, 0);
        check("R7 no early output", vcount - base, 0);
        do_read(1000, 800, 0, 0, 0);
        acc = exp_read(1000, 700, 0) + exp_read(1000, 650, 0) + exp_read(1000, 800, 0);
        check("R7 one output", vcount - base, 1);
        check("R7 total", last_amp, acc);
    endtask

    task automatic t_abort();
        int base;
        longint acc;
        set_cfg(2, 9, 0, 4, 0, 1);
        base = vcount;
        partial_read(5);
        do_read(1200, 1100, 0, 0, 0);
        check("R8 err set", longint'(err_flag), 1);
        check("R8 one output", vcount - base, 1);
        check("R8 clean after abort", last_amp, exp_read(1200, 1100, 0));
        cfg_reads = 4'd2;
        base = vcount;
        do_read(3000, 100, 0, 0, 0);
        partial_read(3);
        do_read(1000, 900, 0, 0, 0);
        check("R8 partial total dropped", vcount - base, 0);
        do_read(1000, 800, 0, 0, 0);
        acc = exp_read(1000, 900, 0) + exp_read(1000, 800, 0);
        check("R8 repeat after abort", last_amp, acc);
        check("R8 err sticky", longint'(err_flag), 1);
    endtask

    task automatic t_fullscale();
        set_cfg(0, 70, 0, 63, 0, 15);
        for (int r = 0; r < 15; r++) do_read(4095, 0, 0, 0, 0);
        check("R9 positive full scale", last_amp, 64'sd7739550);
        for (int r = 0; r < 15; r++) do_read(0, 4095, 0, 0, 0);
        check("R9 negative full scale", last_amp, -64'sd7739550);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_negative_gaps();
        t_long_extra();
        t_dual();
        t_repeat();
        t_abort();
        t_fullscale();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule